// File: doc/BRIEF.md
# LIN Wake-Up Detector

This block watches the digitized level of a LIN bus and a digitized local wake input while the transceiver rests in one of its two quiet modes. It raises a one-cycle remote wake pulse when the bus shows a complete wake pattern. The pattern is a change from recessive to dominant, then a dominant level held for more than a programmable number of clock cycles, then a return to recessive. If the dominant time simply runs past the limit, nothing is flagged: the pulse comes only when the bus releases. A dominant phase that is too short leaves no trace.

It raises a separate one-cycle local wake pulse when the wake input changes level in either direction, but only while the mode controller reports sleep. Remote detection runs in both sleep and standby, so a bus wake can also be reported when the regulator is already on. Keeping the two pulses apart lets the surrounding mode controller record which source woke the node. That record later drives the receive-data pin in standby.

Both inputs pass through a reset-to-recessive synchronizer before any decision is made. All state clears while the controller reports either of the two communicating modes.

Top module: `lwu_wake_detect`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, both `remote_wake_o` and `local_wake_o` are 0. The synchronized bus and wake levels reset to 0.
- R2: In an active mode, a dominant bus (`bus_dom_i`=1) held for D sampled cycles with D > `MIN_DOM_CYCLES`, then released, gives exactly one `remote_wake_o` pulse, one cycle wide. It appears in the cycle after the (`SYNC_STAGES`+1)-th rising clock edge counted from the first recessive sample.
- R3: A dominant phase of D <= `MIN_DOM_CYCLES` sampled cycles, including D equal to the limit, gives no remote pulse, and the detector returns to idle.
- R4: No remote pulse is issued while the bus is still dominant, however long the dominant phase lasts; only the following release can issue it.
- R5: `mode_i` encodes 2'b00 = sleep, 2'b01 = standby, 2'b10 = normal, 2'b11 = normal with reduced slope. Remote detection per R2 works identically in sleep and in standby.
- R6: While `mode_i[1]`=1, neither output pulses in the following cycle. The remote detector is cleared, so a dominant phase that began before a normal-mode interval and ends after it gives no pulse.
- R7: In sleep, each change of `wake_pin_i`, low-to-high or high-to-low, gives one `local_wake_o` pulse, one cycle wide, with the same latency as R2.
- R8: A change of `wake_pin_i` in standby or a normal mode gives no local pulse, neither at once nor on a later entry into sleep.
- R9: After a pulse or an abort the detector accepts a new pattern at once: a single recessive sample between two valid dominant phases yields two remote pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Current operating mode from the mode controller (encoding in R5) |
| bus_dom_i | input | 1 | Digitized bus level, 1 = dominant |
| wake_pin_i | input | 1 | Digitized local wake input |
| remote_wake_o | output | 1 | One-cycle pulse on a completed bus wake pattern |
| local_wake_o | output | 1 | One-cycle pulse on a local wake input change in sleep |

## Verification
The bench builds the block with `MIN_DOM_CYCLES`=4 and `SYNC_STAGES`=2. At these values the full range of dominant lengths, from 1 to three times the limit, can be swept in every one of the four modes. That sweep includes the exact boundary at D = 4 versus D = 5. The two-stage synchronizer fixes the pulse position two cycles after release, which the bench checks exactly. The short limit also keeps the cases affordable: mode changes in the middle of a pattern, back-to-back patterns and both wake-input directions in each mode.

// File: rtl/lwu_pkg.sv
package lwu_pkg;

    // Operating mode as reported by the mode controller.
    typedef enum logic [1:0] {
        MODE_SLEEP      = 2'b00,
        MODE_STANDBY    = 2'b01,
        MODE_NORMAL     = 2'b10,
        MODE_NORMAL_LOW = 2'b11
    } lwu_mode_e;

    // Remote wake pattern tracker states.
    typedef enum logic [1:0] {
        RW_IDLE  = 2'd0,
        RW_DOM   = 2'd1,
        RW_ARMED = 2'd2
    } rw_state_e;

    // Level transitions seen on one synchronized input.
    typedef struct packed {
        logic to_high;
        logic to_low;
    } lvl_edge_t;

    // Remote detection runs in both quiet modes.
    function automatic logic remote_allowed(input logic [1:0] m);
        return (m == MODE_SLEEP) || (m == MODE_STANDBY);
    endfunction

    // Local detection runs in sleep only.
    function automatic logic local_allowed(input logic [1:0] m);
        return m == MODE_SLEEP;
    endfunction

    // Counter width able to hold min_cycles + 1.
    function automatic int unsigned dom_cnt_width(input int unsigned min_cycles);
        return $clog2(min_cycles + 2);
    endfunction

endpackage

// File: rtl/lwu_sync.sv
module lwu_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] sr;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sr <= {STAGES{RST_VAL}};
                end else begin
                    sr[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        sr[i] <= sr[i-1];
                    end
                end
            end
            assign q = sr[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/lwu_edge.sv
module lwu_edge
    import lwu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl,
    output lvl_edge_t ev
);
    logic prev_q;

    // History follows the input in every mode, so re-enabling never
    // invents an edge from a level that settled earlier.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    always_comb begin
        ev.to_high = lvl & ~prev_q;
        ev.to_low  = ~lvl & prev_q;
    end
endmodule

// File: rtl/lwu_remote_fsm.sv
module lwu_remote_fsm
    import lwu_pkg::*;
#(
    parameter int unsigned MIN_DOM_CYCLES = 2000,
    parameter int unsigned CNT_W          = dom_cnt_width(MIN_DOM_CYCLES)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  logic      dom_lvl,
    input  lvl_edge_t ev,
    output logic      wake_pulse
);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_DOM_CYCLES);

    rw_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             fire;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        if (!active) begin
            state_d = RW_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                RW_IDLE: begin
                    if (ev.to_high) begin
                        state_d = RW_DOM;
                        cnt_d   = CNT_W'(1);
                    end
                end
                RW_DOM: begin
                    if (!dom_lvl) begin
                        // too short: abort silently
                        state_d = RW_IDLE;
                        cnt_d   = '0;
                    end else if (cnt_q >= MIN_C) begin
                        // more than the limit seen; wait for release
                        state_d = RW_ARMED;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                RW_ARMED: begin
                    if (ev.to_low) begin
                        fire    = 1'b1;
                        state_d = RW_IDLE;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = RW_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= RW_IDLE;
            cnt_q      <= '0;
            wake_pulse <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            wake_pulse <= fire;
        end
    end
endmodule

// File: rtl/lwu_local_det.sv
module lwu_local_det
    import lwu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  lvl_edge_t ev,
    output logic      wake_pulse
);
    logic changed;

    assign changed = ev.to_high | ev.to_low;

    always_ff @(posedge clk) begin
        if (rst) wake_pulse <= 1'b0;
        else     wake_pulse <= active & changed;
    end
endmodule

// File: rtl/lwu_wake_detect.sv
module lwu_wake_detect
    import lwu_pkg::*;
#(
    parameter int unsigned MIN_DOM_CYCLES = 2000,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    input  logic       bus_dom_i,
    input  logic       wake_pin_i,
    output logic       remote_wake_o,
    output logic       local_wake_o
);
    localparam int unsigned CNT_W = dom_cnt_width(MIN_DOM_CYCLES);

    logic      bus_s, wake_s;
    lvl_edge_t bus_ev, wake_ev;
    logic      remote_on, local_on;

    assign remote_on = remote_allowed(mode_i);
    assign local_on  = local_allowed(mode_i);

    lwu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_bus (
        .clk(clk), .rst(rst), .d(bus_dom_i), .q(bus_s)
    );

    lwu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_wake (
        .clk(clk), .rst(rst), .d(wake_pin_i), .q(wake_s)
    );

    lwu_edge u_edge_bus (
        .clk(clk), .rst(rst), .lvl(bus_s), .ev(bus_ev)
    );

    lwu_edge u_edge_wake (
        .clk(clk), .rst(rst), .lvl(wake_s), .ev(wake_ev)
    );

    lwu_remote_fsm #(.MIN_DOM_CYCLES(MIN_DOM_CYCLES), .CNT_W(CNT_W)) u_remote (
        .clk(clk), .rst(rst), .active(remote_on), .dom_lvl(bus_s),
        .ev(bus_ev), .wake_pulse(remote_wake_o)
    );

    lwu_local_det u_local (
        .clk(clk), .rst(rst), .active(local_on), .ev(wake_ev),
        .wake_pulse(local_wake_o)
    );
endmodule

// File: rtl/lwu_wake_detect_chk.sv
module lwu_wake_detect_chk #(
    parameter int unsigned MIN_DOM_CYCLES = 2000
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_i,
    input logic       bus_s,
    input logic       remote_wake_o,
    input logic       local_wake_o
);
    localparam int unsigned RW = $clog2(MIN_DOM_CYCLES + 2);
    localparam logic [RW-1:0] RUN_MAX = RW'(MIN_DOM_CYCLES + 1);
    localparam logic [RW-1:0] RUN_MIN = RW'(MIN_DOM_CYCLES);

    // Independent run-length of consecutive dominant samples, saturating.
    logic [RW-1:0] run;
    always_ff @(posedge clk) begin
        if (rst)               run <= '0;
        else if (!bus_s)       run <= '0;
        else if (run != RUN_MAX) run <= run + 1'b1;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!remote_wake_o && !local_wake_o));

    a_r2_remote_single_cycle: assert property (@(posedge clk) disable iff (rst)
        remote_wake_o |=> !remote_wake_o);

    a_r3_dominant_long_enough: assert property (@(posedge clk) disable iff (rst)
        remote_wake_o |-> ($past(run) > RUN_MIN));

    a_r4_pulse_on_release: assert property (@(posedge clk) disable iff (rst)
        remote_wake_o |-> (!$past(bus_s) && $past(bus_s, 2)));

    a_r5_remote_quiet_modes: assert property (@(posedge clk) disable iff (rst)
        remote_wake_o |-> !$past(mode_i[1]));

    a_r6_normal_silent: assert property (@(posedge clk) disable iff (rst)
        mode_i[1] |=> (!remote_wake_o && !local_wake_o));

    a_r8_local_sleep_only: assert property (@(posedge clk) disable iff (rst)
        local_wake_o |-> ($past(mode_i) == 2'b00));
endmodule

bind lwu_wake_detect lwu_wake_detect_chk #(.MIN_DOM_CYCLES(MIN_DOM_CYCLES)) u_chk (
    .clk(clk),
    .rst(rst),
    .mode_i(mode_i),
    .bus_s(bus_s),
    .remote_wake_o(remote_wake_o),
    .local_wake_o(local_wake_o)
);

// File: tb/lwu_wake_detect_tb.sv
module lwu_wake_detect_tb;
    localparam int MIN  = 4;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC;   // negedge index of the pulse after release
    localparam int WIN  = SYNC + 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       bus = 1'b0;
    logic       wpin = 1'b0;
    logic       rw, lw;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lwu_wake_detect #(.MIN_DOM_CYCLES(MIN), .SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst(rst), .mode_i(mode), .bus_dom_i(bus),
        .wake_pin_i(wpin), .remote_wake_o(rw), .local_wake_o(lw)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one dominant phase of d samples in mode m and judge the outcome.
    task automatic remote_run(input logic [1:0] m, input int d);
        int    held = 0;
        int    cnt = 0;
        int    pos = -1;
        bit    exp_on;
        string tag;
        @(negedge clk);
        mode = m;
        bus  = 1'b0;
        settle(SYNC + 4);
        bus = 1'b1;
        for (int j = 0; j < d; j++) begin
            @(negedge clk);
            if (rw) held++;
        end
        bus = 1'b0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (rw) begin cnt++; pos = i; end
        end
        exp_on = (m[1] == 1'b0) && (d > MIN);
        if (m[1])            tag = "R6";
        else if (d <= MIN)   tag = "R3";
        else if (m == 2'b01) tag = "R5";
        else                 tag = "R2";
        check("R4", $sformatf("pulses during hold d=%0d mode=%0d", d, m), held, 0);
        check(tag, $sformatf("pulse count d=%0d mode=%0d", d, m), cnt, exp_on ? 1 : 0);
        if (exp_on)
            check("R2", $sformatf("pulse position d=%0d mode=%0d", d, m), pos, LAT);
    endtask

    // Change the wake input to v in mode m and judge the local pulse.
    task automatic local_run(input logic [1:0] m, input logic v);
        int cnt = 0;
        int pos = -1;
        @(negedge clk);
        mode = m;
        settle(SYNC + 4);
        wpin = v;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (lw) begin cnt++; pos = i; end
        end
        if (m == 2'b00) begin
            check("R7", $sformatf("local count v=%0d", v), cnt, 1);
            check("R7", $sformatf("local position v=%0d", v), pos, LAT);
        end else begin
            check("R8", $sformatf("local count mode=%0d v=%0d", m, v), cnt, 0);
        end
    endtask

    initial begin
        int cnt;
        // R1: reset state
        settle(1);
        check("R1", "remote during reset", int'(rw), 0);
        check("R1", "local during reset", int'(lw), 0);
        settle(2);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "remote after reset", int'(rw), 0);
        check("R1", "local after reset", int'(lw), 0);

        // R2 / R3 / R4 / R5 / R6: sweep of dominant length in every mode
        for (int m = 0; m < 4; m++) begin
            for (int d = 1; d <= 3 * MIN + 1; d++) begin
                remote_run(2'(m), d);
            end
        end

        // R6: pattern interrupted by a normal-mode interval
        @(negedge clk);
        mode = 2'b01;
        settle(SYNC + 4);
        bus = 1'b1;
        settle(2 * MIN);
        mode = 2'b10;
        settle(3);
        mode = 2'b01;
        settle(MIN + 3);
        bus = 1'b0;
        cnt = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (rw) cnt++;
        end
        check("R6", "pulse after interrupted pattern", cnt, 0);

        // R9: back-to-back patterns with one recessive sample between
        settle(SYNC + 4);
        cnt = 0;
        bus = 1'b1;
        for (int j = 0; j < MIN + 1; j++) begin @(negedge clk); if (rw) cnt++; end
        bus = 1'b0;
        @(negedge clk); if (rw) cnt++;
        bus = 1'b1;
        for (int j = 0; j < MIN + 1; j++) begin @(negedge clk); if (rw) cnt++; end
        bus = 1'b0;
        for (int i = 0; i < WIN; i++) begin @(negedge clk); if (rw) cnt++; end
        check("R9", "pulses for two adjacent patterns", cnt, 2);

        // R7 / R8: both directions in every mode
        for (int m = 0; m < 4; m++) begin
            local_run(2'(m), 1'b1);
            local_run(2'(m), 1'b0);
        end

        // R8: change made outside sleep must not surface on sleep entry
        for (int m = 1; m < 4; m++) begin
            @(negedge clk);
            mode = 2'(m);
            settle(SYNC + 4);
            wpin = ~wpin;
            settle(SYNC + 4);
            mode = 2'b00;
            cnt = 0;
            for (int i = 0; i < WIN; i++) begin @(negedge clk); if (lw) cnt++; end
            check("R8", $sformatf("late local pulse from mode %0d", m), cnt, 0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual still running expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule